// File: doc/BRIEF.md
# SDRAM Refresh Command Sequencer

This block sits beside an SDRAM memory controller and takes over the command pins while the device is refreshed. An arbiter asks for a burst of auto-refresh operations. If any bank is open at that moment, the sequencer first closes every bank with a precharge-all command and waits out the precharge period. It then issues the requested number of auto-refresh commands, each one row-cycle time after the last. A separate level request puts the device into self-refresh. Again, a precharge-all is issued first if any bank is open. When the request is withdrawn, the sequencer brings clock-enable back up and waits one more row-cycle time.

The auto-refresh request uses a valid/acknowledge handshake. The arbiter raises `req_valid` with a burst count on `req_count` and keeps both steady until `req_ack` pulses. It drops `req_valid` after the pulse. The command pins have no back-pressure. The `ready` output is the grant: the controller may issue its own commands only while `ready` is high. Timing values are parameters counted in clock cycles (`T_RP` precharge, `T_RC` row cycle).

Top module: `refresh_sequencer`

## Requirements
- R1: After reset, and whenever no sequence is running, the pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0), with cke=1, ready=1 and req_ack=0.
- R2: When `req_valid` is sampled high in idle with no bit of `bank_open` set, an auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1) is on the pins in the cycle after that edge.
- R3: If any `bank_open` bit is set when a sequence starts, a precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1) comes first. The next command follows exactly T_RP cycles later, and NOP is driven in between.
- R4: A burst of N auto-refresh commands is issued for `req_count`=N, where 0 counts as 1. Consecutive commands are exactly T_RC cycles apart, with NOP between them.
- R5: `req_ack` is a single-cycle pulse, high in the same cycle as the last auto-refresh command of the burst.
- R6: `ready` is low from the first command cycle of a sequence. It rises exactly T_RC cycles after the last auto-refresh, and every non-NOP command is driven only while `ready` is low.
- R7: When `sr_req` is sampled high in idle, a self-refresh entry is issued (the auto-refresh pin pattern with cke=0). The entry follows a precharge-all when banks are open. cke then stays 0 with NOP pins for as long as `sr_req` stays high.
- R8: The cycle after `sr_req` is sampled low during self-refresh, cke returns to 1 with NOP pins. `ready` rises exactly T_RC cycles after cke rises.
- R9: When `req_valid` and `sr_req` are both high in idle, the auto-refresh burst runs first. Self-refresh entry follows once the sequencer is idle again.
- R10: a10 is high only in a precharge-all cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Auto-refresh burst request, held until acknowledged |
| req_count | input | CNT_W | Number of auto-refresh commands in the burst (0 means 1) |
| req_ack | output | 1 | Pulse marking the last auto-refresh of the burst |
| sr_req | input | 1 | Level request to stay in self-refresh |
| bank_open | input | BANKS | One bit per bank that currently holds an open row |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, selects all banks for precharge |
| cke | output | 1 | Clock enable to the device |
| ready | output | 1 | Grant: the controller may issue access commands |

## Verification
The bench compares every cycle of the pins, `ready`, `req_ack` and `cke` against a timeline that bench functions compute from the burst count, the bank state and the self-refresh hold time. Requests with all banks closed and with some bank open tell apart the precharge-first path and the direct path. Counts of 0, 1 and several separate the zero-as-one rule, the acknowledge position and the row-cycle spacing. Self-refresh holds of zero and of several cycles show that the exit follows the request level and not a fixed delay. A directed case with both requests raised together checks the priority.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    OP_NOP,
    OP_PALL,
    OP_AREF,
    OP_SREF
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_REFW,
    ST_SELF,
    ST_EXITW
  } st_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } pins_t;

  localparam pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};

  function automatic pins_t encode_op(op_e op);
    pins_t p;
    case (op)
      OP_PALL: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
      OP_AREF,
      OP_SREF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
      default: p = PINS_NOP;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rfsh_down_timer.sv
module rfsh_down_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R6
  expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/rfsh_burst_ctr.sv
module rfsh_burst_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         none_left,
  output logic         one_left
);

  logic [W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      rem_q <= '0;
    else if (load)   rem_q <= load_val;
    else if (dec)    rem_q <= rem_q - 1'b1;
  end

  assign none_left = (rem_q == '0);
  assign one_left  = (rem_q == W'(1));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !none_left);

endmodule

// File: rtl/rfsh_pin_reg.sv
module rfsh_pin_reg
  import rfsh_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  op_e   op,
  output pins_t pins_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) pins_q <= PINS_NOP;
    else        pins_q <= encode_op(op);
  end

  // R10
  a10_only_pall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pins_q.a10 |-> (!pins_q.ras_n && pins_q.cas_n && !pins_q.we_n));

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
  import rfsh_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int CNT_W = 4,
  parameter int T_RP  = 3,
  parameter int T_RC  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] req_count,
  output logic             req_ack,
  input  logic             sr_req,
  input  logic [BANKS-1:0] bank_open,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             a10,
  output logic             cke,
  output logic             ready
);

  localparam int TMAX = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] RP_LOAD = TW'(T_RP - 1);
  localparam logic [TW-1:0] RC_LOAD = TW'(T_RC - 1);

  st_e  st_q, st_d;
  op_e  op_d;
  logic self_q, self_d;
  logic cke_q, cke_d;
  logic ready_q, ack_q, ack_d;
  logic t_load, t_exp;
  logic [TW-1:0] t_val;
  logic b_load, b_dec, b_none, b_one;
  logic [CNT_W-1:0] first_rem;
  logic any_open;
  pins_t pins;

  assign any_open  = |bank_open;
  assign first_rem = (req_count == '0) ? '0 : req_count - 1'b1;

  rfsh_down_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  rfsh_burst_ctr #(.W(CNT_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(b_load), .load_val(first_rem), .dec(b_dec),
    .none_left(b_none), .one_left(b_one)
  );

  rfsh_pin_reg u_pins (
    .clk(clk), .rst_n(rst_n), .op(op_d), .pins_q(pins)
  );

  always_comb begin
    st_d   = st_q;
    op_d   = OP_NOP;
    self_d = self_q;
    cke_d  = cke_q;
    ack_d  = 1'b0;
    t_load = 1'b0;
    t_val  = RC_LOAD;
    b_load = 1'b0;
    b_dec  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          self_d = 1'b0;
          if (any_open) begin
            op_d = OP_PALL; t_load = 1'b1; t_val = RP_LOAD; st_d = ST_PRE;
          end else begin
            op_d = OP_AREF; b_load = 1'b1; t_load = 1'b1;
            ack_d = (first_rem == '0); st_d = ST_REFW;
          end
        end else if (sr_req) begin
          self_d = 1'b1;
          if (any_open) begin
            op_d = OP_PALL; t_load = 1'b1; t_val = RP_LOAD; st_d = ST_PRE;
          end else begin
            op_d = OP_SREF; cke_d = 1'b0; st_d = ST_SELF;
          end
        end
      end
      ST_PRE: begin
        if (t_exp) begin
          if (self_q) begin
            op_d = OP_SREF; cke_d = 1'b0; st_d = ST_SELF;
          end else begin
            op_d = OP_AREF; b_load = 1'b1; t_load = 1'b1;
            ack_d = (first_rem == '0); st_d = ST_REFW;
          end
        end
      end
      ST_REFW: begin
        if (t_exp) begin
          if (!b_none) begin
            op_d = OP_AREF; b_dec = 1'b1; t_load = 1'b1; ack_d = b_one;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_SELF: begin
        if (!sr_req) begin
          cke_d = 1'b1; t_load = 1'b1; st_d = ST_EXITW;
        end
      end
      ST_EXITW: begin
        if (t_exp) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      self_q  <= 1'b0;
      cke_q   <= 1'b1;
      ready_q <= 1'b1;
      ack_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      self_q  <= self_d;
      cke_q   <= cke_d;
      ready_q <= (st_d == ST_IDLE);
      ack_q   <= ack_d;
    end
  end

  assign cs_n    = pins.cs_n;
  assign ras_n   = pins.ras_n;
  assign cas_n   = pins.cas_n;
  assign we_n    = pins.we_n;
  assign a10     = pins.a10;
  assign cke     = cke_q;
  assign ready   = ready_q;
  assign req_ack = ack_q;

  // Checker state: cycles since the last auto-refresh or self-refresh exit.
  localparam logic [TW:0] RC_W = (TW+1)'(T_RC);
  logic [TW:0] since_q;
  logic        cke_prev;
  logic        ref_on, cmd_on;

  assign ref_on = !cs_n && !ras_n && !cas_n && we_n && cke;
  assign cmd_on = !cs_n && !(ras_n && cas_n && we_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q  <= RC_W;
      cke_prev <= 1'b1;
    end else begin
      cke_prev <= cke;
      if (ref_on || (cke && !cke_prev)) since_q <= (TW+1)'(1);
      else if (since_q < RC_W)          since_q <= since_q + 1'b1;
    end
  end

  // R4
  aref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_on |-> (since_q >= RC_W));

  // R5
  ack_with_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> ref_on);

  // R6
  busy_when_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_on |-> !ready);

  // R8
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (since_q >= RC_W));

  // R7
  cke_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (!cs_n && !ras_n && !cas_n && we_n));

endmodule

// File: tb/refresh_sequencer_test.sv
module refresh_sequencer_test;

  localparam int BANKS = 4;
  localparam int CNT_W = 4;
  localparam int T_RP  = 3;
  localparam int T_RC  = 8;

  localparam int C_NOP = 0, C_PALL = 1, C_AREF = 2, C_SREF = 3, C_BAD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [CNT_W-1:0] req_count = '0;
  logic sr_req = 1'b0;
  logic [BANKS-1:0] bank_open = '0;
  logic req_ack, cs_n, ras_n, cas_n, we_n, a10, cke, ready;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  refresh_sequencer #(.BANKS(BANKS), .CNT_W(CNT_W), .T_RP(T_RP), .T_RC(T_RC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_count(req_count),
    .req_ack(req_ack), .sr_req(sr_req), .bank_open(bank_open),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10),
    .cke(cke), .ready(ready)
  );

  function automatic int decode();
    if (!cs_n && ras_n && cas_n && we_n)    return C_NOP;
    if (!cs_n && !ras_n && cas_n && !we_n)  return C_PALL;
    if (!cs_n && !ras_n && !cas_n && we_n)  return cke ? C_AREF : C_SREF;
    return C_BAD;
  endfunction

  function automatic int exp_auto_op(int t, int n, bit open);
    int t0 = open ? 1 + T_RP : 1;
    if (open && t == 1) return C_PALL;
    if (t >= t0 && ((t - t0) % T_RC) == 0 && ((t - t0) / T_RC) < n) return C_AREF;
    return C_NOP;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_cycles(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      check(decode() == C_NOP, "R1 idle pins", decode(), C_NOP);
      check(ready == 1'b1 && cke == 1'b1 && req_ack == 1'b0 && a10 == 1'b0,
            "R1 idle ready/cke/ack/a10", {ready, cke, req_ack, a10}, 4'b1100);
    end
  endtask

  // Auto-refresh burst; sr_req is left as the caller set it.
  task automatic do_auto(int cnt, bit open);
    int n    = (cnt == 0) ? 1 : cnt;
    int t0   = open ? 1 + T_RP : 1;
    int last = t0 + (n - 1) * T_RC;
    int tend = last + T_RC;
    req_valid = 1'b1;
    req_count = CNT_W'(cnt);
    bank_open = open ? BANKS'(4'b0100) : '0;
    for (int t = 1; t <= tend; t++) begin
      int eo;
      @(negedge clk);
      eo = exp_auto_op(t, n, open);
      check(decode() == eo, open ? "R3 R4 R2 command sequence" : "R2 R4 command sequence", decode(), eo);
      check(a10 == (eo == C_PALL), "R10 a10", a10, int'(eo == C_PALL));
      check(ready == (t >= tend), "R6 ready window", ready, int'(t >= tend));
      check(req_ack == (t == last), "R5 ack position", req_ack, int'(t == last));
      check(cke == 1'b1, "R2 cke during auto refresh", cke, 1);
      if (t == last) req_valid = 1'b0;
    end
  endtask

  task automatic do_self(bit open, int hold);
    int t0   = open ? 1 + T_RP : 1;
    int tx   = t0 + hold + 1;
    int tend = tx + T_RC;
    sr_req    = 1'b1;
    bank_open = open ? BANKS'(4'b0001) : '0;
    for (int t = 1; t <= tend; t++) begin
      int eo;
      bit ecke;
      @(negedge clk);
      eo   = (open && t == 1) ? C_PALL : ((t == t0) ? C_SREF : C_NOP);
      ecke = !(t >= t0 && t < tx);
      check(decode() == eo, open ? "R7 R3 self entry sequence" : "R7 self entry sequence", decode(), eo);
      check(cke == ecke, "R7 R8 cke level", cke, int'(ecke));
      check(ready == (t >= tend), "R8 ready after exit", ready, int'(t >= tend));
      check(req_ack == 1'b0, "R5 no ack in self refresh", req_ack, 0);
      if (t == t0 + hold) sr_req = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(decode() == C_NOP, "R1 reset pins", decode(), C_NOP);
    check(ready && cke && !req_ack, "R1 reset outputs", {ready, cke, req_ack}, 3'b110);
    rst_n = 1'b1;
    idle_cycles(2);

    // Directed corners
    do_auto(1, 1'b0);  idle_cycles(1);
    do_auto(0, 1'b0);  idle_cycles(1);   // R4 zero counts as one
    do_auto(3, 1'b1);  idle_cycles(2);
    do_self(1'b0, 0);  idle_cycles(1);
    do_self(1'b1, 4);  idle_cycles(1);

    // R9: both requests at once, auto refresh wins
    sr_req = 1'b1;
    do_auto(2, 1'b0);
    do_self(1'b0, 2);
    idle_cycles(2);

    // Constrained random mix
    for (int i = 0; i < 40; i++) begin
      bit open = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 2) != 0) do_auto(int'($urandom_range(0, 5)), open);
      else                           do_self(open, int'($urandom_range(0, 6)));
      idle_cycles(int'($urandom_range(1, 3)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule